// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block is one byte-wide digital I/O port as a small controller's register bus sees it. Software sees three byte registers. The first sets which pins drive, the second holds the value driven on outputs and the pull-up choice on inputs, and the third is a read-only view of the pad levels. Every write carries a per-bit mask, so software can set or clear a single bit without a read-modify-write sequence. It can also flip any output bits by writing ones to the read-only pin address.

Each pin's pad controls come from a small per-pin multiplexer. An output enable, an output level and a pull-up enable are normally derived from the two writable registers. A peripheral can take over any single pin through its alternate-function override inputs without disturbing the others. A global pull-up kill input turns off every pull-up in the port. Pad inputs pass through a two-flop synchronizer before they can be read.

Top module: `gpio_port`

## Requirements
- R1: A synchronous active-high reset clears the direction and data registers, the synchronizer and the read data. With no override active, pad_oe, pad_out, pad_pu and rd_data are all 0 after reset.
- R2: The address map has four offsets. Offset 0 is the pin register, offset 1 the direction register and offset 2 the data register. Offset 3 is unmapped: it reads as 0, and writes to it change nothing.
- R3: A write to offset 1 or 2 updates only the bits whose wr_mask bit is 1. A mask of all ones is a full-byte write, and a one-hot mask is a single-bit set or clear.
- R4: A write to offset 0 inverts each data-register bit where both wr_data and wr_mask are 1. All other data bits keep their value, and the direction register is untouched.
- R5: The pin register is read-only. After any write to offset 0, reading offset 0 still returns the synchronized pad inputs.
- R6: pad_in passes through two synchronizer flops and then the read register. A change on pad_in shows up in rd_data at offset 0 on the third rising edge after it, and not on the second.
- R7: For a pin with no override, pad_oe equals its direction bit (1 = output) and pad_out equals its data bit.
- R8: For a pin with no override, pad_pu is 1 exactly when the direction bit is 0, the data bit is 1 and pu_kill is 0.
- R9: While pu_kill is 1, every bit of pad_pu is 0, whether or not that pin is overridden.
- R10: When alt_en[n] is 1, pin n takes its output enable from alt_oe[n], its output level from alt_out[n] and its pull-up from alt_pu[n] (gated by pu_kill). All other pins are unaffected.
- R11: rd_data is registered: after each rising edge it holds the register selected by bus_addr in the cycle before that edge, as the register stood before any write on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset (0 pin, 1 direction, 2 data, 3 unmapped) |
| bus_wr | input | 1 | Write strobe for the current cycle |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write enable |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pad input levels |
| pu_kill | input | 1 | Global pull-up disable |
| alt_en | input | 8 | Per-pin alternate-function override enable |
| alt_oe | input | 8 | Override output enable |
| alt_out | input | 8 | Override output level |
| alt_pu | input | 8 | Override pull-up enable |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output level |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
The assertions check the following on every cycle:
- the pull-up kill holding all pull-ups off;
- overridden pins following the alternate inputs;
- the masked direction write and the toggle write landing as seen on non-overridden pads;
- the unmapped offset reading zero and leaving the pads alone.

Other behaviours can only be shown by the bench's scenarios. These are the three-edge synchronizer latency, the pin register keeping the pad value after toggle writes, and the exact pull-up values across direction and data combinations. The scenarios also show overrides releasing pins back to their register values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int SYNC_N  = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PIN  = 2'd0,
        OFS_DIR  = 2'd1,
        OFS_DATA = 2'd2,
        OFS_NONE = 2'd3
    } port_ofs_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;

    // Register-driven pad controls for one pin.
    function automatic pad_ctl_t normal_ctl(input logic dir_b, input logic dat_b,
                                            input logic kill);
        pad_ctl_t c;
        c.oe  = dir_b;
        c.out = dat_b;
        c.pu  = ~dir_b & dat_b & ~kill;
        return c;
    endfunction

    // Masked merge of new data into a register.
    function automatic logic [PORT_W-1:0] merge_bits(input logic [PORT_W-1:0] cur,
                                                     input logic [PORT_W-1:0] nxt,
                                                     input logic [PORT_W-1:0] msk);
        return (cur & ~msk) | (nxt & msk);
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = gpio_port_pkg::PORT_W,
    parameter int STAGES = gpio_port_pkg::SYNC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  port_ofs_e    ofs,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] dat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            case (ofs)
                OFS_DIR:  dir_q <= merge_bits(dir_q, wdata, wmask);
                OFS_DATA: dat_q <= merge_bits(dat_q, wdata, wmask);
                OFS_PIN:  dat_q <= dat_q ^ (wdata & wmask);
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] dat_q,
    input  logic         kill,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_oe,
    input  logic [W-1:0] ovr_out,
    input  logic [W-1:0] ovr_pu,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] pu
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        pad_ctl_t nrm, alt, sel;
        always_comb begin
            nrm     = normal_ctl(dir_q[n], dat_q[n], kill);
            alt.oe  = ovr_oe[n];
            alt.out = ovr_out[n];
            alt.pu  = ovr_pu[n] & ~kill;
            sel     = ovr_en[n] ? alt : nrm;
        end
        assign oe[n]  = sel.oe;
        assign out[n] = sel.out;
        assign pu[n]  = sel.pu;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  wr_mask,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic              pu_kill,
    input  logic [WIDTH-1:0]  alt_en,
    input  logic [WIDTH-1:0]  alt_oe,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic [WIDTH-1:0]  alt_pu,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu
);
    port_ofs_e        ofs;
    logic [WIDTH-1:0] dir_q, dat_q, pin_q, rd_nxt;

    assign ofs = port_ofs_e'(bus_addr);

    gpio_port_regs #(.W(WIDTH)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .ofs(ofs),
        .wdata(wr_data), .wmask(wr_mask), .dir_q(dir_q), .dat_q(dat_q)
    );

    gpio_port_sync #(.W(WIDTH), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_q)
    );

    gpio_port_padmux #(.W(WIDTH)) u_mux (
        .dir_q(dir_q), .dat_q(dat_q), .kill(pu_kill),
        .ovr_en(alt_en), .ovr_oe(alt_oe), .ovr_out(alt_out), .ovr_pu(alt_pu),
        .oe(pad_oe), .out(pad_out), .pu(pad_pu)
    );

    always_comb begin
        case (ofs)
            OFS_PIN:  rd_nxt = pin_q;
            OFS_DIR:  rd_nxt = dir_q;
            OFS_DATA: rd_nxt = dat_q;
            default:  rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_nxt;
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = gpio_port_pkg::PORT_W
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] wr_mask,
    input logic [W-1:0] rd_data,
    input logic         pu_kill,
    input logic [W-1:0] alt_en,
    input logic [W-1:0] alt_oe,
    input logic [W-1:0] alt_out,
    input logic [W-1:0] alt_pu,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_pu
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (((pad_oe | pad_pu) & ~alt_en) == '0 && rd_data == '0));

    // R9
    pu_kill_chk: assert property (@(posedge clk) disable iff (rst)
        pu_kill |-> pad_pu == '0);

    // R10
    ovr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & alt_en) == (alt_oe & alt_en)) &&
        ((pad_out & alt_en) == (alt_out & alt_en)));

    // R3
    masked_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && alt_en == '0) |=>
        (alt_en != '0) || (pad_oe == (($past(pad_oe) & ~$past(wr_mask)) |
                                      ($past(wr_data) & $past(wr_mask)))));

    // R4
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && alt_en == '0) |=>
        (alt_en != '0) || (pad_out == ($past(pad_out) ^ ($past(wr_data) & $past(wr_mask)))));

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |=> rd_data == '0);

    // R2
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3 && alt_en == '0) |=>
        (alt_en != '0) || ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_port gpio_port_chk #(.W(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data), .pu_kill(pu_kill),
    .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .alt_pu(alt_pu),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] wr_data = '0, wr_mask = '0, rd_data;
    logic [7:0] pad_in = '0;
    logic       pu_kill = 1'b0;
    logic [7:0] alt_en = '0, alt_oe = '0, alt_out = '0, alt_pu = '0;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data), .pad_in(pad_in),
        .pu_kill(pu_kill), .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
        .alt_pu(alt_pu), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_mask = m; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out", pad_out, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        check("R1 rd", rd_data, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_full();
        logic [7:0] v;
        wr(2'd1, 8'hA5, 8'hFF);
        wr(2'd2, 8'h3C, 8'hFF);
        rd(2'd1, v); check("R2/R11 dir read", v, 8'hA5);
        rd(2'd2, v); check("R2/R11 data read", v, 8'h3C);
        check("R7 oe", pad_oe, 8'hA5);
        check("R7 out", pad_out, 8'h3C);
        check("R8 pu", pad_pu, 8'h18);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        wr(2'd1, 8'hFF, 8'h02);
        rd(2'd1, v); check("R3 dir set bit1", v, 8'hA7);
        wr(2'd2, 8'h00, 8'h04);
        rd(2'd2, v); check("R3 data clear bit2", v, 8'h38);
        wr(2'd1, 8'h00, 8'h80);
        rd(2'd1, v); check("R3 dir clear bit7", v, 8'h27);
        check("R3 pad_oe", pad_oe, 8'h27);
    endtask

    task automatic t_toggle();
        logic [7:0] v;
        wr(2'd0, 8'h0F, 8'hFF);
        rd(2'd2, v); check("R4 toggle low nibble", v, 8'h37);
        wr(2'd0, 8'hF0, 8'h10);
        rd(2'd2, v); check("R4 masked toggle", v, 8'h27);
        rd(2'd1, v); check("R4 dir untouched", v, 8'h27);
        rd(2'd0, v); check("R5 pin reg read-only", v, 8'h5C);
    endtask

    task automatic t_sync();
        @(negedge clk);
        bus_addr = 2'd0; pad_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        check("R6 not yet at edge 2", rd_data, 8'h5C);
        @(negedge clk);
        check("R6 visible at edge 3", rd_data, 8'hC3);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        rd(2'd3, v); check("R2 unmapped reads zero", v, 8'h00);
        wr(2'd3, 8'hFF, 8'hFF);
        rd(2'd1, v); check("R2 unmapped write dir", v, 8'h27);
        rd(2'd2, v); check("R2 unmapped write data", v, 8'h27);
    endtask

    task automatic t_pullup();
        wr(2'd1, 8'h00, 8'hFF);
        wr(2'd2, 8'hFF, 8'hFF);
        check("R8 all pulled", pad_pu, 8'hFF);
        @(negedge clk); pu_kill = 1'b1; #1;
        check("R9 kill", pad_pu, 8'h00);
        @(negedge clk); pu_kill = 1'b0; #1;
        check("R9 release", pad_pu, 8'hFF);
    endtask

    task automatic t_override();
        @(negedge clk);
        alt_en = 8'h01; alt_oe = 8'h01; alt_out = 8'h00; alt_pu = 8'h00; #1;
        check("R10 pin0 oe", pad_oe, 8'h01);
        check("R10 pin0 out", pad_out, 8'hFE);
        check("R10 pin0 pu", pad_pu, 8'hFE);
        @(negedge clk);
        alt_en = 8'h10; alt_oe = 8'h00; alt_out = 8'h00; alt_pu = 8'h10; #1;
        check("R10 pin4 out", pad_out, 8'hEF);
        check("R10 pin4 pu", pad_pu, 8'hFF);
        @(negedge clk); pu_kill = 1'b1; #1;
        check("R9 kill overridden", pad_pu, 8'h00);
        @(negedge clk); pu_kill = 1'b0; alt_en = 8'h00; #1;
        check("R10 released", pad_out, 8'hFF);
    endtask

    initial begin
        pad_in = 8'h5C;
        t_reset();
        t_full();
        t_masked();
        t_toggle();
        t_sync();
        t_unmapped();
        t_pullup();
        t_override();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule